// File: doc/BRIEF.md
# Instruction Control Decoder

This block turns the opcode and function fields of a 32-bit, three-register-format instruction into the control lines for a single-cycle datapath. It is purely combinational: every output follows the two input fields in the same cycle. The register file, the ALU, the memories and the program counter are outside the block.

Decoding happens in two stages. A main stage reads only the opcode. It produces the datapath steering lines and a 2-bit ALU class code, with values add, subtract, use-function and add-immediate. An ALU stage reads that class code and looks at the function field only when the class is use-function. Any opcode outside the supported set raises `illegal_o`, and so does any function value outside the supported set when the opcode is zero. An illegal instruction clears every control line, so it cannot change state.

Top module: `instr_ctrl_decoder`

## Requirements
- R1: With opcode 0 and function 32, 34, 36, 37 or 39, the block sets `reg_dst_o` and `reg_write_o` and clears every other control line and `illegal_o`. `alu_fn_o` is then 0 (add), 1 (sub), 2 (and), 3 (or) or 4 (nor) respectively.
- R2: With opcode 0 and function 8, the instruction is a jump through a register. The block sets `jump_reg_o` and clears all other control lines, including `reg_write_o`. `alu_fn_o` is 0.
- R3: Opcode 35 (load word) sets `alu_src_o`, `mem_to_reg_o` and `reg_write_o`, clears the other control lines, and sets `alu_fn_o` to 0 (add).
- R4: Opcode 43 (store word) sets `alu_src_o` and `mem_write_o`, clears the other control lines including `reg_write_o`, and sets `alu_fn_o` to 0.
- R5: Opcode 4 (branch if equal) sets only `branch_eq_o` and sets `alu_fn_o` to 1 (subtract).
- R6: Opcode 5 (branch if not equal) sets only `branch_ne_o` and sets `alu_fn_o` to 1.
- R7: Opcode 8 (add immediate) sets `alu_src_o` and `reg_write_o`, clears the other control lines including `reg_dst_o`, and sets `alu_fn_o` to 0.
- R8: For every supported non-zero opcode, the function field has no effect on any output.
- R9: Any opcode outside {0, 4, 5, 8, 35, 43} sets `illegal_o`, clears all eight control lines, and sets `alu_fn_o` to 0.
- R10: Opcode 0 with a function outside {8, 32, 34, 36, 37, 39} sets `illegal_o`, clears all eight control lines, and sets `alu_fn_o` to 0.
- R11: `reg_write_o` and `mem_write_o` are never high together, and at most one of `branch_eq_o`, `branch_ne_o` and `jump_reg_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode_i | input | 6 | Primary opcode field of the instruction |
| funct_i | input | 6 | Function field, used only when the opcode is 0 |
| reg_dst_o | output | 1 | Write destination comes from the third register field |
| alu_src_o | output | 1 | ALU second operand is the sign-extended immediate |
| mem_to_reg_o | output | 1 | Register write data comes from data memory |
| reg_write_o | output | 1 | Register file write enable |
| mem_write_o | output | 1 | Data memory write enable |
| branch_eq_o | output | 1 | Take the branch when the ALU result is zero |
| branch_ne_o | output | 1 | Take the branch when the ALU result is non-zero |
| jump_reg_o | output | 1 | Next program counter comes from a register |
| alu_fn_o | output | 3 | ALU operation: 0 add, 1 sub, 2 and, 3 or, 4 nor |
| illegal_o | output | 1 | Unsupported opcode or function value |

## Verification
Every result is due in the same cycle as its stimulus, with zero register stages between the input fields and any output. The driver applies a new opcode/function pair just after a rising edge and queues the expected outputs at the same time. The monitor pops the queued item and compares it at the following falling edge, half a period later, after the combinational outputs have settled. The bench sweeps all 4096 opcode/function pairs and adds directed cases, so the check for ignored fields and the checks for illegal encodings cover every value.

// File: rtl/ctrl_dec_pkg.sv
package ctrl_dec_pkg;
  localparam int OPC_W = 6;
  localparam int FN_W  = 6;
  localparam int ALU_FN_W = 3;

  // opcode values
  localparam int OP_RTYPE = 0;
  localparam int OP_BEQ   = 4;
  localparam int OP_BNE   = 5;
  localparam int OP_ADDI  = 8;
  localparam int OP_LW    = 35;
  localparam int OP_SW    = 43;

  // function values under opcode 0
  localparam int FN_JR  = 8;
  localparam int FN_ADD = 32;
  localparam int FN_SUB = 34;
  localparam int FN_AND = 36;
  localparam int FN_OR  = 37;
  localparam int FN_NOR = 39;

  typedef enum logic [1:0] {
    AOP_ADD   = 2'b00,
    AOP_SUB   = 2'b01,
    AOP_FUNCT = 2'b10,
    AOP_ADDI  = 2'b11
  } alu_class_e;

  typedef enum logic [ALU_FN_W-1:0] {
    ALU_ADD = 3'd0,
    ALU_SUB = 3'd1,
    ALU_AND = 3'd2,
    ALU_OR  = 3'd3,
    ALU_NOR = 3'd4
  } alu_fn_e;

  typedef struct packed {
    logic reg_dst;
    logic alu_src;
    logic mem_to_reg;
    logic reg_write;
    logic mem_write;
    logic br_eq;
    logic br_ne;
    logic jump_reg;
  } ctrl_t;
endpackage

// File: rtl/ctrl_main_dec.sv
module ctrl_main_dec
  import ctrl_dec_pkg::*;
#(
  parameter int OPC_W = ctrl_dec_pkg::OPC_W
) (
  input  logic [OPC_W-1:0] opcode_i,
  output ctrl_t            ctrl_o,
  output alu_class_e       alu_class_o,
  output logic             op_ok_o
);
  always_comb begin
    ctrl_o      = '0;
    alu_class_o = AOP_ADD;
    op_ok_o     = 1'b1;
    case (opcode_i)
      OPC_W'(OP_RTYPE): begin
        ctrl_o.reg_dst   = 1'b1;
        ctrl_o.reg_write = 1'b1;
        alu_class_o      = AOP_FUNCT;
      end
      OPC_W'(OP_LW): begin
        ctrl_o.alu_src    = 1'b1;
        ctrl_o.mem_to_reg = 1'b1;
        ctrl_o.reg_write  = 1'b1;
      end
      OPC_W'(OP_SW): begin
        ctrl_o.alu_src   = 1'b1;
        ctrl_o.mem_write = 1'b1;
      end
      OPC_W'(OP_BEQ): begin
        ctrl_o.br_eq = 1'b1;
        alu_class_o  = AOP_SUB;
      end
      OPC_W'(OP_BNE): begin
        ctrl_o.br_ne = 1'b1;
        alu_class_o  = AOP_SUB;
      end
      OPC_W'(OP_ADDI): begin
        ctrl_o.alu_src   = 1'b1;
        ctrl_o.reg_write = 1'b1;
        alu_class_o      = AOP_ADDI;
      end
      default: op_ok_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/ctrl_alu_dec.sv
module ctrl_alu_dec
  import ctrl_dec_pkg::*;
#(
  parameter int FN_W = ctrl_dec_pkg::FN_W
) (
  input  alu_class_e      alu_class_i,
  input  logic [FN_W-1:0] funct_i,
  output alu_fn_e         alu_fn_o,
  output logic            is_jr_o,
  output logic            fn_ok_o
);
  always_comb begin
    alu_fn_o = ALU_ADD;
    is_jr_o  = 1'b0;
    fn_ok_o  = 1'b1;
    case (alu_class_i)
      AOP_SUB:   alu_fn_o = ALU_SUB;
      AOP_FUNCT: begin
        case (funct_i)
          FN_W'(FN_ADD): alu_fn_o = ALU_ADD;
          FN_W'(FN_SUB): alu_fn_o = ALU_SUB;
          FN_W'(FN_AND): alu_fn_o = ALU_AND;
          FN_W'(FN_OR):  alu_fn_o = ALU_OR;
          FN_W'(FN_NOR): alu_fn_o = ALU_NOR;
          FN_W'(FN_JR):  is_jr_o  = 1'b1;
          default:       fn_ok_o  = 1'b0;
        endcase
      end
      default:   alu_fn_o = ALU_ADD; // load, store, add immediate
    endcase
  end
endmodule

// File: rtl/instr_ctrl_decoder.sv
module instr_ctrl_decoder
  import ctrl_dec_pkg::*;
#(
  parameter int OPC_W    = ctrl_dec_pkg::OPC_W,
  parameter int FN_W     = ctrl_dec_pkg::FN_W,
  parameter int ALU_FN_W = ctrl_dec_pkg::ALU_FN_W
) (
  input  logic [OPC_W-1:0]    opcode_i,
  input  logic [FN_W-1:0]     funct_i,
  output logic                reg_dst_o,
  output logic                alu_src_o,
  output logic                mem_to_reg_o,
  output logic                reg_write_o,
  output logic                mem_write_o,
  output logic                branch_eq_o,
  output logic                branch_ne_o,
  output logic                jump_reg_o,
  output logic [ALU_FN_W-1:0] alu_fn_o,
  output logic                illegal_o
);
  ctrl_t      base_ctrl;
  ctrl_t      fin_ctrl;
  alu_class_e alu_class;
  alu_fn_e    alu_fn;
  logic       op_ok, fn_ok, is_jr, legal;

  ctrl_main_dec #(.OPC_W(OPC_W)) u_main (
    .opcode_i    (opcode_i),
    .ctrl_o      (base_ctrl),
    .alu_class_o (alu_class),
    .op_ok_o     (op_ok)
  );

  ctrl_alu_dec #(.FN_W(FN_W)) u_alu (
    .alu_class_i (alu_class),
    .funct_i     (funct_i),
    .alu_fn_o    (alu_fn),
    .is_jr_o     (is_jr),
    .fn_ok_o     (fn_ok)
  );

  assign legal = op_ok & fn_ok;

  always_comb begin
    fin_ctrl = base_ctrl;
    if (is_jr) begin
      // register jump reads rs only: no write-back
      fin_ctrl          = '0;
      fin_ctrl.jump_reg = 1'b1;
    end
    if (!legal) fin_ctrl = '0;
  end

  assign reg_dst_o    = fin_ctrl.reg_dst;
  assign alu_src_o    = fin_ctrl.alu_src;
  assign mem_to_reg_o = fin_ctrl.mem_to_reg;
  assign reg_write_o  = fin_ctrl.reg_write;
  assign mem_write_o  = fin_ctrl.mem_write;
  assign branch_eq_o  = fin_ctrl.br_eq;
  assign branch_ne_o  = fin_ctrl.br_ne;
  assign jump_reg_o   = fin_ctrl.jump_reg;
  assign alu_fn_o     = legal ? ALU_FN_W'(alu_fn) : ALU_FN_W'(ALU_ADD);
  assign illegal_o    = ~legal;
endmodule

// File: rtl/instr_ctrl_decoder_chk.sv
module instr_ctrl_decoder_chk #(
  parameter int OPC_W    = 6,
  parameter int FN_W     = 6,
  parameter int ALU_FN_W = 3
) (
  input logic [OPC_W-1:0]    opcode_i,
  input logic [FN_W-1:0]     funct_i,
  input logic                reg_dst_o,
  input logic                alu_src_o,
  input logic                mem_to_reg_o,
  input logic                reg_write_o,
  input logic                mem_write_o,
  input logic                branch_eq_o,
  input logic                branch_ne_o,
  input logic                jump_reg_o,
  input logic [ALU_FN_W-1:0] alu_fn_o,
  input logic                illegal_o
);
  logic any_ctrl;
  assign any_ctrl = reg_dst_o | alu_src_o | mem_to_reg_o | reg_write_o |
                    mem_write_o | branch_eq_o | branch_ne_o | jump_reg_o;

  always_comb begin
    assert_no_dual_write_R11: assert (!(reg_write_o && mem_write_o))
      else $error("reg and mem write both high");
    assert_one_redirect_R11: assert ($onehot0({branch_eq_o, branch_ne_o, jump_reg_o}))
      else $error("more than one redirect");
    assert_illegal_quiet_R9: assert (!illegal_o || !any_ctrl)
      else $error("control active on illegal instruction");
    assert_jr_no_write_R2: assert (!jump_reg_o || !reg_write_o)
      else $error("register jump writes back");
    assert_store_adds_R4: assert (!mem_write_o || (alu_fn_o == 3'd0 && alu_src_o))
      else $error("store without add on immediate");
    assert_branch_subs_R5: assert (!(branch_eq_o || branch_ne_o) || alu_fn_o == 3'd1)
      else $error("branch without subtract");
    assert_rtype_only_dst_R1: assert (!reg_dst_o || opcode_i == '0)
      else $error("register destination outside opcode 0");
    assert_funct_unused_R8: assert (opcode_i == '0 || !illegal_o ||
                                     !(opcode_i == 6'd4 || opcode_i == 6'd5 ||
                                       opcode_i == 6'd8 || opcode_i == 6'd35 ||
                                       opcode_i == 6'd43))
      else $error("supported opcode flagged illegal");
  end
endmodule

bind instr_ctrl_decoder instr_ctrl_decoder_chk #(
  .OPC_W(OPC_W), .FN_W(FN_W), .ALU_FN_W(ALU_FN_W)
) u_chk (
  .opcode_i     (opcode_i),
  .funct_i      (funct_i),
  .reg_dst_o    (reg_dst_o),
  .alu_src_o    (alu_src_o),
  .mem_to_reg_o (mem_to_reg_o),
  .reg_write_o  (reg_write_o),
  .mem_write_o  (mem_write_o),
  .branch_eq_o  (branch_eq_o),
  .branch_ne_o  (branch_ne_o),
  .jump_reg_o   (jump_reg_o),
  .alu_fn_o     (alu_fn_o),
  .illegal_o    (illegal_o)
);

// File: tb/instr_ctrl_decoder_tb_top.sv
module instr_ctrl_decoder_tb_top;
  // packed result: {reg_dst, alu_src, mem_to_reg, reg_write, mem_write,
  //                 br_eq, br_ne, jump_reg, alu_fn[2:0], illegal}
  typedef logic [11:0] res_t;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [5:0] opcode;
  logic [5:0] funct;
  logic       reg_dst, alu_src, mem_to_reg, reg_write, mem_write;
  logic       br_eq, br_ne, jump_reg, illegal;
  logic [2:0] alu_fn;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  res_t  exp_q[$];
  string tag_q[$];
  string dsc_q[$];

  always #10 clk = ~clk; // 50 MHz

  instr_ctrl_decoder dut_i (
    .opcode_i     (opcode),
    .funct_i      (funct),
    .reg_dst_o    (reg_dst),
    .alu_src_o    (alu_src),
    .mem_to_reg_o (mem_to_reg),
    .reg_write_o  (reg_write),
    .mem_write_o  (mem_write),
    .branch_eq_o  (br_eq),
    .branch_ne_o  (br_ne),
    .jump_reg_o   (jump_reg),
    .alu_fn_o     (alu_fn),
    .illegal_o    (illegal)
  );

  function automatic res_t mk(input logic [7:0] c, input logic [2:0] fn, input logic ill);
    return {c, fn, ill};
  endfunction

  // expected values from the requirement table
  function automatic res_t model(input int op, input int fn, output string tag);
    case (op)
      0: begin
        case (fn)
          32: begin tag = "R1"; return mk(8'b1001_0000, 3'd0, 1'b0); end
          34: begin tag = "R1"; return mk(8'b1001_0000, 3'd1, 1'b0); end
          36: begin tag = "R1"; return mk(8'b1001_0000, 3'd2, 1'b0); end
          37: begin tag = "R1"; return mk(8'b1001_0000, 3'd3, 1'b0); end
          39: begin tag = "R1"; return mk(8'b1001_0000, 3'd4, 1'b0); end
          8:  begin tag = "R2"; return mk(8'b0000_0001, 3'd0, 1'b0); end
          default: begin tag = "R10"; return mk(8'b0, 3'd0, 1'b1); end
        endcase
      end
      35: begin tag = (fn == 0) ? "R3" : "R8"; return mk(8'b0111_0000, 3'd0, 1'b0); end
      43: begin tag = (fn == 0) ? "R4" : "R8"; return mk(8'b0100_1000, 3'd0, 1'b0); end
      4:  begin tag = (fn == 0) ? "R5" : "R8"; return mk(8'b0000_0100, 3'd1, 1'b0); end
      5:  begin tag = (fn == 0) ? "R6" : "R8"; return mk(8'b0000_0010, 3'd1, 1'b0); end
      8:  begin tag = (fn == 0) ? "R7" : "R8"; return mk(8'b0101_0000, 3'd0, 1'b0); end
      default: begin tag = "R9"; return mk(8'b0, 3'd0, 1'b1); end
    endcase
  endfunction

  task automatic drive(input int op, input int fn, input string note);
    string t;
    res_t  e;
    @(posedge clk);
    #1;
    opcode = 6'(op);
    funct  = 6'(fn);
    e = model(op, fn, t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    dsc_q.push_back(note);
  endtask

  // monitor: results are due in the same cycle, compared at the falling edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      res_t  e;
      res_t  a;
      string t;
      string d;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      d = dsc_q.pop_front();
      a = {reg_dst, alu_src, mem_to_reg, reg_write, mem_write,
           br_eq, br_ne, jump_reg, alu_fn, illegal};
      n_checks++;
      if (a !== e) begin
        n_fail++;
        $display("FAIL %s %s op=%0d fn=%0d actual=%b expected=%b",
                 t, d, opcode, funct, a, e);
      end
      // R11: exclusivity checked on every vector
      n_checks++;
      if ((reg_write && mem_write) || (int'(br_eq) + int'(br_ne) + int'(jump_reg) > 1)) begin
        n_fail++;
        $display("FAIL R11 exclusivity op=%0d fn=%0d actual=%b expected=no overlap",
                 opcode, funct, a);
      end
    end
  end

  initial begin
    opcode = '0;
    funct  = '0;
    repeat (3) @(posedge clk);
    drive(0, 0, "reset-state input, R10 undefined funct");
    rst_ni = 1'b1;
    // directed
    drive(0, 32, "R1 add");
    drive(0, 34, "R1 sub");
    drive(0, 36, "R1 and");
    drive(0, 37, "R1 or");
    drive(0, 39, "R1 nor");
    drive(0, 8,  "R2 jr");
    drive(35, 0, "R3 lw");
    drive(43, 0, "R4 sw");
    drive(4, 0,  "R5 beq");
    drive(5, 0,  "R6 bne");
    drive(8, 0,  "R7 addi");
    drive(35, 39, "R8 lw with nor funct");
    drive(8, 34,  "R8 addi with sub funct");
    drive(4, 63,  "R8 beq with junk funct");
    drive(2, 32,  "R9 unsupported opcode");
    drive(63, 0,  "R9 top opcode");
    drive(0, 33,  "R10 unsupported funct");
    drive(0, 63,  "R10 top funct");
    // exhaustive sweep
    for (int o = 0; o < 64; o++)
      for (int f = 0; f < 64; f++)
        drive(o, f, "sweep");
    @(posedge clk);
    @(negedge clk);
    @(posedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule